// File: doc/BRIEF.md
# Video line timing sequencer for a serial display link

This block paces one video-mode frame at a time for a serial display transmitter. A horizontal counter runs in lane byte clock cycles and splits each line into a sync-active phase, a back-porch phase and the remainder of the line. A line counter walks the vertical regions of the frame. From this state the block raises single-cycle events that tell a downstream packetizer when to send a frame-start sync packet, a line-start sync packet, a sync-end packet and the header of an active pixel packet. It also raises level requests that say whether the current cycle should carry pixel payload, blanking, or may drop the lanes to low power.

The parallel pixel interface sync and data-enable inputs each pass through a polarity bit and come out normalized and registered. An asserted edge on the normalized vertical sync restarts the frame, so the sequencer locks to the pixel source. A power-up control holds every counter at the frame origin while it is low. The timing fields are expected to stay static while the sequencer runs.

Top module: `dsi_line_seq`

## Requirements
- R1: While `pwr_on` is low, all event and request outputs are 0, the sync outputs are 0, and the counters stay at the frame origin. The first cycle after `pwr_on` rises is cycle 0 of line 0 of the first non-empty vertical region.
- R2: A line lasts `hline_cyc` cycles, or 1 cycle when `hline_cyc` is 0. `ev_hss` pulses on cycle 0 of every line, except where `ev_vss` takes its place.
- R3: `ev_vss` pulses on cycle 0 of line 0 of the vertical sync region, and never together with `ev_hss`.
- R4: `vreg` encodes the vertical region as sync=0, back porch=1, active=2, front porch=3. The regions follow that order and wrap to the next frame. Each region lasts its programmed line count.
- R5: A region whose line count is 0 is skipped. If all counts are 0, the region advances by one on every line.
- R6: `ev_hse` pulses on cycle `hsa_cyc` of every line when `vid_type[0]` is 0 (pulse modes 0 and 2). It never pulses when `vid_type[0]` is 1.
- R7: In active lines only, `ev_pix` pulses on cycle `hsa_cyc+hbp_cyc` and then shows `pix_len`=`pkt_size` and `pix_vc`=`vc`; both fields are 0 otherwise. `pix_act` is high for ceil(`pkt_size`*BYTES_PX/LANES) cycles from that cycle.
- R8: `lp_req` is 0 during the sync-active phase and during pixel payload. In other cycles of lines outside the active region it equals `lp_en[vreg]`. In active lines it is `lp_en[2]&lp_en[4]` in the back-porch phase and `lp_en[2]&lp_en[5]` after the payload.
- R9: `blk_req` is high exactly when the cycle is past the sync-active phase, carries no payload, and `lp_req` is low.
- R10: `sync_hs`, `sync_vs` and `sync_de` are the inputs XOR `pol[0]`, `pol[1]` and `pol[2]` respectively, one cycle later. A set bit marks an active-low input.
- R11: A cycle where the normalized vertical sync is high and `sync_vs` is low restarts the frame: the next cycle is at the frame origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous-free active-low reset |
| pwr_on | input | 1 | Power-up; low holds the sequencer at the origin |
| hsa_cyc | input | HW | Horizontal sync-active length, cycles |
| hbp_cyc | input | HW | Horizontal back porch length, cycles |
| hline_cyc | input | HW | Total line length, cycles |
| vsa_lines | input | VW | Vertical sync lines |
| vbp_lines | input | VW | Vertical back porch lines |
| vact_lines | input | VW | Active lines |
| vfp_lines | input | VW | Vertical front porch lines |
| pkt_size | input | PW | Active pixels per line |
| vid_type | input | 2 | Transmission type; 2 is burst with sync pulses |
| vc | input | 2 | Virtual channel for pixel packets |
| lp_en | input | 6 | Low-power permission: [0] vsync, [1] vbp, [2] vactive, [3] vfp, [4] hbp, [5] hfp |
| pol | input | 3 | Active-low flags: [0] hsync, [1] vsync, [2] data enable |
| dpi_hsync | input | 1 | Pixel source horizontal sync |
| dpi_vsync | input | 1 | Pixel source vertical sync |
| dpi_de | input | 1 | Pixel source data enable |
| sync_hs | output | 1 | Normalized, registered horizontal sync |
| sync_vs | output | 1 | Normalized, registered vertical sync |
| sync_de | output | 1 | Normalized, registered data enable |
| vreg | output | 2 | Current vertical region |
| ev_vss | output | 1 | Frame-start sync packet event |
| ev_hss | output | 1 | Line-start sync packet event |
| ev_hse | output | 1 | Sync-end packet event |
| ev_pix | output | 1 | Pixel packet start event |
| pix_act | output | 1 | Pixel payload cycle |
| lp_req | output | 1 | Low power allowed this cycle |
| blk_req | output | 1 | Blanking payload this cycle |
| pix_len | output | PW | Pixel count, valid with `ev_pix` |
| pix_vc | output | 2 | Virtual channel, valid with `ev_pix` |

## Verification
The bench builds the block with HW=10, VW=6, BYTES_PX=3 and LANES=2. Short lines of a few dozen cycles and frames of a handful of lines therefore run through many complete frames. LANES=2 makes the payload length a rounded-up fraction (5 pixels give 8 cycles), so the ceiling is tested. A zero line length makes every cycle a new line, which puts the wrap, skip and restart paths on consecutive clocks.

// File: rtl/dsi_line_seq.sv
module dsi_line_seq #(
  parameter int HW = 16,
  parameter int VW = 12,
  parameter int PW = 14,
  parameter int BYTES_PX = 3,
  parameter int LANES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on,
  input  logic [HW-1:0] hsa_cyc,
  input  logic [HW-1:0] hbp_cyc,
  input  logic [HW-1:0] hline_cyc,
  input  logic [VW-1:0] vsa_lines,
  input  logic [VW-1:0] vbp_lines,
  input  logic [VW-1:0] vact_lines,
  input  logic [VW-1:0] vfp_lines,
  input  logic [PW-1:0] pkt_size,
  input  logic [1:0]    vid_type,
  input  logic [1:0]    vc,
  input  logic [5:0]    lp_en,
  input  logic [2:0]    pol,
  input  logic          dpi_hsync,
  input  logic          dpi_vsync,
  input  logic          dpi_de,
  output logic          sync_hs,
  output logic          sync_vs,
  output logic          sync_de,
  output logic [1:0]    vreg,
  output logic          ev_vss,
  output logic          ev_hss,
  output logic          ev_hse,
  output logic          ev_pix,
  output logic          pix_act,
  output logic          lp_req,
  output logic          blk_req,
  output logic [PW-1:0] pix_len,
  output logic [1:0]    pix_vc
);
  localparam int AW = ((HW > PW + 3) ? HW : PW + 3) + 2;
  localparam logic [1:0] RG_VSA = 2'd0;
  localparam logic [1:0] RG_ACT = 2'd2;

  logic [HW-1:0] hcnt;
  logic [VW-1:0] lcnt;
  logic [1:0]    region;
  logic [VW-1:0] seg_len;
  logic [3:0]    nz;
  logic          vs_n, restart, line_end, seg_end;
  logic [AW-1:0] hpos, b_act, act_cyc, b_end;
  logic          ph_hsa, ph_hbp, ph_pix, in_act;

  function automatic logic [1:0] pick(input logic [1:0] s, input logic [3:0] m);
    logic [1:0] r;
    logic       hit;
    r = s;
    hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (!hit && m[2'(s + 2'(k))]) begin
        r = 2'(s + 2'(k));
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  assign nz = {vfp_lines != '0, vact_lines != '0, vbp_lines != '0, vsa_lines != '0};

  always_comb begin
    case (region)
      2'd0:    seg_len = vsa_lines;
      2'd1:    seg_len = vbp_lines;
      2'd2:    seg_len = vact_lines;
      default: seg_len = vfp_lines;
    endcase
  end

  assign vs_n     = dpi_vsync ^ pol[1];
  assign restart  = vs_n & ~sync_vs;
  assign line_end = ({1'b0, hcnt} + 1'b1) >= {1'b0, hline_cyc};
  assign seg_end  = ({1'b0, lcnt} + 1'b1) >= {1'b0, seg_len};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0; lcnt <= '0; region <= RG_VSA;
      sync_hs <= 1'b0; sync_vs <= 1'b0; sync_de <= 1'b0;
    end else if (!pwr_on) begin
      hcnt <= '0; lcnt <= '0; region <= pick(RG_VSA, nz);
      sync_hs <= 1'b0; sync_vs <= 1'b0; sync_de <= 1'b0;
    end else begin
      sync_hs <= dpi_hsync ^ pol[0];
      sync_vs <= vs_n;
      sync_de <= dpi_de ^ pol[2];
      if (restart) begin
        hcnt <= '0; lcnt <= '0; region <= pick(RG_VSA, nz);
      end else if (line_end) begin
        hcnt <= '0;
        if (seg_end) begin
          lcnt <= '0;
          region <= pick(region + 2'd1, nz);
        end else begin
          lcnt <= lcnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign hpos    = AW'(hcnt);
  assign b_act   = AW'(hsa_cyc) + AW'(hbp_cyc);
  assign act_cyc = (AW'(pkt_size) * AW'(BYTES_PX) + AW'(LANES - 1)) / AW'(LANES);
  assign b_end   = b_act + act_cyc;
  assign in_act  = region == RG_ACT;
  assign ph_hsa  = hcnt < hsa_cyc;
  assign ph_hbp  = !ph_hsa && hpos < b_act;
  assign ph_pix  = in_act && hpos >= b_act && hpos < b_end;

  assign vreg    = region;
  assign ev_vss  = pwr_on && hcnt == '0 && region == RG_VSA && lcnt == '0;
  assign ev_hss  = pwr_on && hcnt == '0 && !ev_vss;
  assign ev_hse  = pwr_on && !vid_type[0] && hcnt == hsa_cyc;
  assign ev_pix  = pwr_on && in_act && hpos == b_act;
  assign pix_act = pwr_on && ph_pix;
  assign pix_len = ev_pix ? pkt_size : '0;
  assign pix_vc  = ev_pix ? vc : 2'd0;
  assign lp_req  = pwr_on && !ph_hsa &&
                   (in_act ? (ph_hbp ? (lp_en[2] & lp_en[4])
                                     : (!ph_pix && lp_en[2] && lp_en[5]))
                           : lp_en[region]);
  assign blk_req = pwr_on && !ph_hsa && !ph_pix && !lp_req;

  p_start_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_vss && ev_hss));
  p_pwr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> (hcnt == '0 && lcnt == '0 && !sync_vs));
  p_line_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && hcnt < hline_cyc) |=> (hcnt < hline_cyc || !$stable(hline_cyc)));
  p_region_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && $past(pwr_on) && region != $past(region)) |-> hcnt == '0);
  p_pix_vact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_act |-> vreg == RG_ACT);
  p_lp_no_pix_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_req && pix_act));
  p_blk_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({blk_req, lp_req, pix_act}) <= 1);
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && restart) |=> (hcnt == '0 && lcnt == '0));
endmodule

// File: tb/dsi_line_seq_test.sv
`timescale 1ns/1ps
module dsi_line_seq_test;
  localparam int HW = 10, VW = 6, PW = 14, BYTES_PX = 3, LANES = 2;

  logic clk = 1'b0;
  logic rst_n, pwr_on;
  logic [HW-1:0] hsa_cyc, hbp_cyc, hline_cyc;
  logic [VW-1:0] vsa_lines, vbp_lines, vact_lines, vfp_lines;
  logic [PW-1:0] pkt_size;
  logic [1:0] vid_type, vc;
  logic [5:0] lp_en;
  logic [2:0] pol;
  logic dpi_hsync, dpi_vsync, dpi_de;
  logic sync_hs, sync_vs, sync_de;
  logic [1:0] vreg;
  logic ev_vss, ev_hss, ev_hse, ev_pix, pix_act, lp_req, blk_req;
  logic [PW-1:0] pix_len;
  logic [1:0] pix_vc;

  int tests = 0, fails = 0;
  int h = 0, l = 0, r = 0;
  bit mhs = 0, mvs = 0, mde = 0;

  always #2.5 clk = ~clk;

  dsi_line_seq #(.HW(HW), .VW(VW), .PW(PW), .BYTES_PX(BYTES_PX), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
    .hsa_cyc(hsa_cyc), .hbp_cyc(hbp_cyc), .hline_cyc(hline_cyc),
    .vsa_lines(vsa_lines), .vbp_lines(vbp_lines), .vact_lines(vact_lines),
    .vfp_lines(vfp_lines), .pkt_size(pkt_size), .vid_type(vid_type), .vc(vc),
    .lp_en(lp_en), .pol(pol), .dpi_hsync(dpi_hsync), .dpi_vsync(dpi_vsync),
    .dpi_de(dpi_de), .sync_hs(sync_hs), .sync_vs(sync_vs), .sync_de(sync_de),
    .vreg(vreg), .ev_vss(ev_vss), .ev_hss(ev_hss), .ev_hse(ev_hse),
    .ev_pix(ev_pix), .pix_act(pix_act), .lp_req(lp_req), .blk_req(blk_req),
    .pix_len(pix_len), .pix_vc(pix_vc));

  function automatic int seglen(int x);
    case (x)
      0: return int'(vsa_lines);
      1: return int'(vbp_lines);
      2: return int'(vact_lines);
      default: return int'(vfp_lines);
    endcase
  endfunction

  function automatic int first_nz(int s);
    for (int k = 0; k < 4; k++)
      if (seglen((s + k) % 4) != 0) return (s + k) % 4;
    return s % 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      h = 0; l = 0; r = 0; mhs = 0; mvs = 0; mde = 0;
    end else if (!pwr_on) begin
      h = 0; l = 0; r = first_nz(0); mhs = 0; mvs = 0; mde = 0;
    end else begin
      bit nvs, rs;
      nvs = dpi_vsync ^ pol[1];
      rs = nvs && !mvs;
      mhs = dpi_hsync ^ pol[0];
      mvs = nvs;
      mde = dpi_de ^ pol[2];
      if (rs) begin
        h = 0; l = 0; r = first_nz(0);
      end else if (h + 1 >= int'(hline_cyc)) begin
        h = 0;
        if (l + 1 >= seglen(r)) begin l = 0; r = first_nz((r + 1) % 4); end
        else l = l + 1;
      end else h = h + 1;
    end
  end

  task automatic chk(string tag, string name, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: got %0d expected %0d", tag, name, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit run, inact, phsa, phbp, ppix, e_vss, e_pix, lp;
      int b2, b3;
      run = pwr_on;
      b2 = int'(hsa_cyc) + int'(hbp_cyc);
      b3 = b2 + (int'(pkt_size) * BYTES_PX + LANES - 1) / LANES;
      inact = (r == 2);
      phsa = h < int'(hsa_cyc);
      phbp = !phsa && h < b2;
      ppix = inact && h >= b2 && h < b3;
      e_vss = run && h == 0 && r == 0 && l == 0;
      e_pix = run && inact && h == b2;
      lp = run && !phsa && (inact ? (phbp ? (lp_en[2] && lp_en[4])
                                          : (!ppix && lp_en[2] && lp_en[5]))
                                  : lp_en[r]);
      chk("R1", "sync_vs", sync_vs, mvs);
      chk("R10", "sync_hs", sync_hs, mhs);
      chk("R10", "sync_de", sync_de, mde);
      chk("R4", "vreg", vreg, r);
      chk("R3", "ev_vss", ev_vss, e_vss);
      chk("R2", "ev_hss", ev_hss, run && h == 0 && !e_vss);
      chk("R6", "ev_hse", ev_hse, run && !vid_type[0] && h == int'(hsa_cyc));
      chk("R7", "ev_pix", ev_pix, e_pix);
      chk("R7", "pix_act", pix_act, run && ppix);
      chk("R7", "pix_len", pix_len, e_pix ? int'(pkt_size) : 0);
      chk("R7", "pix_vc", pix_vc, e_pix ? int'(vc) : 0);
      chk("R8", "lp_req", lp_req, lp);
      chk("R9", "blk_req", blk_req, run && !phsa && !ppix && !lp);
    end else begin
      chk("R1", "reset ev_vss", ev_vss, 0);
      chk("R1", "reset sync_vs", sync_vs, 0);
      chk("R4", "reset vreg", vreg, 0);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dpi_hsync = ((i / 3) % 2) != 0;
      dpi_de = ((i / 5) % 2) != 0;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    rst_n = 0; pwr_on = 0; pol = 3'b000;
    dpi_hsync = 0; dpi_vsync = 0; dpi_de = 0;
    hsa_cyc = 4; hbp_cyc = 3; hline_cyc = 30;
    vsa_lines = 2; vbp_lines = 2; vact_lines = 3; vfp_lines = 2;
    pkt_size = 5; vid_type = 2'd0; vc = 2'd3; lp_en = 6'b111111;
    cycles(4);
    @(negedge clk); rst_n = 1;
    cycles(6);                                   // R1: held while off
    @(negedge clk); pwr_on = 1;
    cycles(600);                                 // R2 R3 R4 R6 R7 R8 over two frames
    @(negedge clk); pwr_on = 0; lp_en = 6'b010110;
    vid_type = 2'd1; pol = 3'b111; dpi_vsync = 1;
    hline_cyc = 17; hsa_cyc = 2; hbp_cyc = 5; pkt_size = 3; vc = 2'd1;
    vsa_lines = 1; vbp_lines = 0; vact_lines = 2; vfp_lines = 0;
    cycles(3);
    @(negedge clk); pwr_on = 1;
    cycles(250);                                 // R5 skip, R6 no sync end, R10 inverted
    @(negedge clk); dpi_vsync = 0;               // R11 asserted (active low)
    cycles(3);
    @(negedge clk); dpi_vsync = 1;
    cycles(120);
    @(negedge clk); vid_type = 2'd2; lp_en = 6'b101101; pol = 3'b000; dpi_vsync = 0;
    hline_cyc = 0; hsa_cyc = 0; hbp_cyc = 0; pkt_size = 1;
    vsa_lines = 3; vbp_lines = 1; vact_lines = 2; vfp_lines = 1;
    cycles(40);                                  // R2 single-cycle lines
    @(negedge clk); dpi_vsync = 1;               // R11 restart
    cycles(2);
    @(negedge clk); dpi_vsync = 0;
    cycles(15);
    @(negedge clk); pwr_on = 0;                  // R1 drop mid frame
    cycles(5);
    @(negedge clk); vsa_lines = 0; vbp_lines = 0; vact_lines = 0; vfp_lines = 0;
    hline_cyc = 3; pwr_on = 1;
    cycles(30);                                  // R5 all regions empty
    finish_run();
  end
endmodule